// File: doc/BRIEF.md
# Register Write Protection Unit

This block holds the timing configuration of a set of chip selects and guards it against stray software writes. Each chip select owns four registers: setup, pulse, cycle and mode. A separate guard register carries one enable bit. While that bit is set, any write aimed at one of the chip-select registers is dropped, the register keeps its old contents, and the attempt is logged in a status register. The log holds a sticky violation flag and the word address of the most recent blocked write.

Software reads the status register to learn whether anything was blocked and where. The flag clears as a side effect of that read. The recorded address is left alone by the read. The guard register itself is never protected, so protection can always be switched off again. The bus has separate write and read addresses, so a write and a read can happen in the same clock. A combinational allow output tells the register owner, for every write, whether it goes through.

Top module: `wprot_regs`

## Requirements
- R1: After reset, every chip-select register, the guard register and the status register read as zero.
- R2: With protection off, a write to chip-select register word address 4*cs+k (k: 0 setup, 1 pulse, 2 cycle, 3 mode) stores the full data word, and a later read of that address returns it.
- R3: The guard register sits at word address PROT_ADDR (default 56). Bit 0 is the protect enable. It reads back as that bit in position 0, with zeros elsewhere.
- R4: While protection is on, a write to any chip-select register leaves its contents unchanged.
- R5: A blocked write sets bit 0 of the status register, at word address STAT_ADDR (default 57), from the next cycle on.
- R6: Status bits [8 +: ADDR_W] hold the word address of the most recent blocked write.
- R7: A read of the status register clears the flag from the next cycle on. It leaves the recorded address unchanged.
- R8: If a blocked write and a status read happen in the same clock, the flag stays set and the address field takes the new write address.
- R9: Writes to the guard register are never blocked, so writing 0 while protection is on turns protection off.
- R10: wr_allow is high in exactly those cycles where bus_wr is high and the write is not blocked. It is a combinational function of the current inputs and state.
- R11: Writes to the status register or to an unmapped address change no register. A read of an unmapped address returns zero. With bus_rd low, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | ADDR_W | Word address of the write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | ADDR_W | Word address of the read |
| bus_rdata | output | DATA_W | Read data: same cycle when RDATA_REG=0, next cycle when 1 |
| wr_allow | output | 1 | High when the current write takes effect |

## Verification
The guard logic is first driven by directed sequences that separate its cases. There is a blocked write with the guard off and then on. There are two successive violations, which show that the address field tracks the latest one. A clearing read is followed by a second read, which tells a clear apart from a mere report. A violation is placed in the same clock as a status read, which exposes a clear that wins wrongly. Protection is also turned off while it is on. After that, a seeded random mix of writes, reads and simultaneous read/write cycles runs over the protected, guard, status and unmapped addresses. It toggles the enable often, so that any mismatch between the allow output, the stored contents and the status log shows up against a bench model.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

   localparam int REGS_PER_CS = 4;
   localparam int SRC_LSB     = 8;

   typedef enum logic [1:0] {
      RK_SETUP = 2'd0,
      RK_PULSE = 2'd1,
      RK_CYCLE = 2'd2,
      RK_MODE  = 2'd3
   } reg_kind_e;

   function automatic int unsigned num_regs(input int unsigned n_cs);
      return n_cs * REGS_PER_CS;
   endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
   import wprot_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int ADDR_W    = 6,
   parameter int PROT_ADDR = 56,
   parameter int STAT_ADDR = 57,
   localparam int NREG     = num_regs(NUM_CS),
   localparam int IDX_W    = $clog2(NREG)
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              prot_en,
   output logic              cfg_we,
   output logic [IDX_W-1:0]  cfg_widx,
   output logic              prot_we,
   output logic              violation,
   output logic              allow,
   output logic              rd_cfg,
   output logic [IDX_W-1:0]  cfg_ridx,
   output logic              rd_prot,
   output logic              rd_stat
);
   localparam logic [ADDR_W:0]   NREG_A = (ADDR_W+1)'(NREG);
   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic w_in_cfg;
   logic r_in_cfg;

   always_comb begin
      w_in_cfg  = ({1'b0, waddr} < NREG_A);
      r_in_cfg  = ({1'b0, raddr} < NREG_A);
      violation = wr && w_in_cfg && prot_en;
      cfg_we    = wr && w_in_cfg && !prot_en;
      cfg_widx  = waddr[IDX_W-1:0];
      prot_we   = wr && (waddr == PROT_A);
      allow     = wr && !violation;
      rd_cfg    = rd && r_in_cfg;
      cfg_ridx  = raddr[IDX_W-1:0];
      rd_prot   = rd && (raddr == PROT_A);
      rd_stat   = rd && (raddr == STAT_A);
   end

endmodule

// File: rtl/wprot_cfg_bank.sv
module wprot_cfg_bank
   import wprot_pkg::*;
#(
   parameter int NUM_CS  = 4,
   parameter int DATA_W  = 32,
   localparam int NREG   = num_regs(NUM_CS),
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IDX_W-1:0]            widx,
   input  logic [DATA_W-1:0]           wdata,
   output logic [NREG-1:0][DATA_W-1:0] cfg_q
);
   for (genvar cs = 0; cs < NUM_CS; cs++) begin : g_cs
      for (genvar k = 0; k < REGS_PER_CS; k++) begin : g_kind
         localparam int          SLOT   = cs * REGS_PER_CS + k;
         localparam logic [IDX_W-1:0] SLOT_I = IDX_W'(SLOT);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_q[SLOT] <= '0;
            end else if (we && (widx == SLOT_I)) begin
               cfg_q[SLOT] <= wdata;
            end
         end
      end
   end

endmodule

// File: rtl/wprot_status.sv
module wprot_status #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              violation,
   input  logic [ADDR_W-1:0] viol_addr,
   input  logic              stat_rd,
   output logic              flag_q,
   output logic [ADDR_W-1:0] src_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         src_q  <= '0;
      end else begin
         if (violation) begin
            flag_q <= 1'b1;
            src_q  <= viol_addr;
         end else if (stat_rd) begin
            flag_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
   import wprot_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int PROT_ADDR = 56,
   parameter int STAT_ADDR = 57,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_waddr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wr_allow
);
   localparam int NREG  = num_regs(NUM_CS);
   localparam int IDX_W = $clog2(NREG);

   if (NUM_CS < 1) begin : g_chk_cs
      $error("NUM_CS must be at least 1");
   end
   if (NREG > (1 << ADDR_W)) begin : g_chk_space
      $error("ADDR_W too small for the chip-select registers");
   end
   if (PROT_ADDR < NREG || STAT_ADDR < NREG) begin : g_chk_overlap
      $error("guard and status addresses must lie above the chip-select registers");
   end
   if (PROT_ADDR == STAT_ADDR) begin : g_chk_same
      $error("guard and status addresses must differ");
   end
   if (PROT_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_chk_range
      $error("guard or status address outside the address space");
   end
   if (DATA_W < SRC_LSB + ADDR_W) begin : g_chk_data
      $error("DATA_W too small for the status address field");
   end

   logic                        prot_en_q;
   logic                        cfg_we;
   logic [IDX_W-1:0]            cfg_widx;
   logic                        prot_we;
   logic                        violation;
   logic                        rd_cfg;
   logic [IDX_W-1:0]            cfg_ridx;
   logic                        rd_prot;
   logic                        rd_stat;
   logic [NREG-1:0][DATA_W-1:0] cfg_q;
   logic                        flag_q;
   logic [ADDR_W-1:0]           src_q;
   logic [DATA_W-1:0]           rd_mux;

   wprot_decode #(
      .NUM_CS   (NUM_CS),
      .ADDR_W   (ADDR_W),
      .PROT_ADDR(PROT_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) i_decode (
      .wr       (bus_wr),
      .waddr    (bus_waddr),
      .rd       (bus_rd),
      .raddr    (bus_raddr),
      .prot_en  (prot_en_q),
      .cfg_we   (cfg_we),
      .cfg_widx (cfg_widx),
      .prot_we  (prot_we),
      .violation(violation),
      .allow    (wr_allow),
      .rd_cfg   (rd_cfg),
      .cfg_ridx (cfg_ridx),
      .rd_prot  (rd_prot),
      .rd_stat  (rd_stat)
   );

   wprot_cfg_bank #(
      .NUM_CS(NUM_CS),
      .DATA_W(DATA_W)
   ) i_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .widx (cfg_widx),
      .wdata(bus_wdata),
      .cfg_q(cfg_q)
   );

   wprot_status #(
      .ADDR_W(ADDR_W)
   ) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .violation(violation),
      .viol_addr(bus_waddr),
      .stat_rd  (rd_stat),
      .flag_q   (flag_q),
      .src_q    (src_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_en_q <= 1'b0;
      end else if (prot_we) begin
         prot_en_q <= bus_wdata[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (rd_cfg) begin
         rd_mux = cfg_q[cfg_ridx];
      end else if (rd_prot) begin
         rd_mux[0] = prot_en_q;
      end else if (rd_stat) begin
         rd_mux[0]                = flag_q;
         rd_mux[SRC_LSB +: ADDR_W] = src_q;
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bus_rdata <= '0;
         end else begin
            bus_rdata <= rd_mux;
         end
      end
   end else begin : g_rd_comb
      always_comb bus_rdata = rd_mux;
   end

endmodule

// File: rtl/wprot_chk.sv
module wprot_chk
   import wprot_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int PROT_ADDR = 56,
   parameter int STAT_ADDR = 57,
   localparam int NREG     = num_regs(NUM_CS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_waddr,
   input logic [DATA_W-1:0]           bus_wdata,
   input logic                        bus_rd,
   input logic [ADDR_W-1:0]           bus_raddr,
   input logic                        wr_allow,
   input logic                        prot_en_q,
   input logic                        flag_q,
   input logic [ADDR_W-1:0]           src_q,
   input logic [NREG-1:0][DATA_W-1:0] cfg_q
);
   localparam logic [ADDR_W:0]   NREG_A = (ADDR_W+1)'(NREG);
   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic blocked;
   logic stat_read;
   logic idle_wr;
   assign blocked   = bus_wr && prot_en_q && ({1'b0, bus_waddr} < NREG_A);
   assign stat_read = bus_rd && (bus_raddr == STAT_A);
   assign idle_wr   = bus_wr && ({1'b0, bus_waddr} >= NREG_A) && (bus_waddr != PROT_A);

   // R4
   a_r4_blocked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> $stable(cfg_q));
   // R5
   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> flag_q);
   // R6
   a_r6_src_latest: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (src_q == $past(bus_waddr)));
   // R7
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && !blocked) |=> !flag_q);
   a_r7_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && !blocked) |=> $stable(src_q));
   // R8
   a_r8_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && blocked) |=> flag_q);
   // R9
   a_r9_guard_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_waddr == PROT_A) |=> (prot_en_q == $past(bus_wdata[0])));
   // R10
   a_r10_allow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_allow == (bus_wr && !blocked));
   // R11
   a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      idle_wr |=> ($stable(cfg_q) && $stable(prot_en_q)));

endmodule

bind wprot_regs wprot_chk #(
   .NUM_CS   (NUM_CS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PROT_ADDR(PROT_ADDR),
   .STAT_ADDR(STAT_ADDR)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_waddr(bus_waddr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .bus_raddr(bus_raddr),
   .wr_allow (wr_allow),
   .prot_en_q(prot_en_q),
   .flag_q   (flag_q),
   .src_q    (src_q),
   .cfg_q    (cfg_q)
);

// File: tb/test_wprot_regs.sv
module test_wprot_regs;
   localparam int NUM_CS    = 4;
   localparam int ADDR_W    = 6;
   localparam int DATA_W    = 32;
   localparam int PROT_ADDR = 56;
   localparam int STAT_ADDR = 57;
   localparam bit RDATA_REG = 1'b0;
   localparam int NREG      = NUM_CS * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_waddr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_raddr = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              wr_allow;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DATA_W-1:0] m_cfg [NREG];
   bit                m_en;
   bit                m_flag;
   logic [ADDR_W-1:0] m_src;

   always #2.5 clk = ~clk;

   wprot_regs #(
      .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR), .RDATA_REG(RDATA_REG)
   ) i_wprot_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
      .bus_rdata(bus_rdata), .wr_allow(wr_allow)
   );

   function automatic logic [DATA_W-1:0] exp_read(input int a);
      logic [DATA_W-1:0] v;
      v = '0;
      if (a < NREG) v = m_cfg[a];
      else if (a == PROT_ADDR) v[0] = m_en;
      else if (a == STAT_ADDR) begin
         v[0] = m_flag;
         v[8 +: ADDR_W] = m_src;
      end
      return v;
   endfunction

   function automatic string tag_of(input int a);
      if (a < NREG) return "R4";
      if (a == PROT_ADDR) return "R3";
      if (a == STAT_ADDR) return "R6";
      return "R11";
   endfunction

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle; rtag empty means the random-phase default label
   task automatic op(input bit w, input int wa, input logic [DATA_W-1:0] wd,
                     input bit r, input int ra, input string rtag);
      bit viol;
      logic [DATA_W-1:0] er;
      string t;
      @(negedge clk);
      bus_wr    = w;
      bus_waddr = ADDR_W'(wa);
      bus_wdata = wd;
      bus_rd    = r;
      bus_raddr = ADDR_W'(ra);
      viol = w && m_en && (wa < NREG);
      er   = r ? exp_read(ra) : '0;
      t    = (rtag == "") ? tag_of(ra) : rtag;
      #1;
      check("R10", {31'd0, wr_allow}, {31'd0, w && !viol});
      if (!RDATA_REG) check(t, bus_rdata, er);
      @(posedge clk);
      if (w && !viol && wa < NREG) m_cfg[wa] = wd;
      if (w && wa == PROT_ADDR) m_en = wd[0];
      if (viol) begin
         m_flag = 1'b1;
         m_src  = ADDR_W'(wa);
      end else if (r && ra == STAT_ADDR) begin
         m_flag = 1'b0;
      end
      if (RDATA_REG) begin
         #1;
         check(t, bus_rdata, er);
      end
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) m_cfg[i] = '0;
      m_en = 1'b0; m_flag = 1'b0; m_src = '0;
      void'($urandom(32'h1234_abcd));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < NREG; i++) op(1'b0, 0, '0, 1'b1, i, "R1");
      op(1'b0, 0, '0, 1'b1, PROT_ADDR, "R1");
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R1");
      // R11: idle read strobe gives zero
      op(1'b0, 0, '0, 1'b0, 3, "R11");

      // R2: unprotected writes land
      for (int i = 0; i < NREG; i++) op(1'b1, i, 32'hA500_0000 + i, 1'b0, 0, "");
      for (int i = 0; i < NREG; i++) op(1'b0, 0, '0, 1'b1, i, "R2");

      // R3: enable protection
      op(1'b1, PROT_ADDR, 32'hFFFF_FFFF, 1'b0, 0, "");
      op(1'b0, 0, '0, 1'b1, PROT_ADDR, "R3");

      // R4, R5, R6: blocked write
      op(1'b1, 5, 32'h1111_2222, 1'b0, 0, "");
      op(1'b0, 0, '0, 1'b1, 5, "R4");
      op(1'b1, 14, 32'h3333_4444, 1'b0, 0, "");
      op(1'b0, 0, '0, 1'b1, 14, "R4");
      // R7: read clears flag, keeps source 14
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R6");
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R7");

      // R8: blocked write in the same clock as a status read
      op(1'b1, 9, 32'h5555_6666, 1'b1, STAT_ADDR, "R7");
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R8");
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R7");

      // R9: guard register writable while protected
      op(1'b1, PROT_ADDR, 32'h0, 1'b0, 0, "");
      op(1'b1, 7, 32'hCAFE_F00D, 1'b0, 0, "");
      op(1'b0, 0, '0, 1'b1, 7, "R9");
      op(1'b0, 0, '0, 1'b1, PROT_ADDR, "R9");

      // R11: status and unmapped writes change nothing
      op(1'b1, STAT_ADDR, 32'hFFFF_FFFF, 1'b0, 0, "");
      op(1'b1, 40, 32'hFFFF_FFFF, 1'b1, 40, "R11");
      op(1'b0, 0, '0, 1'b1, STAT_ADDR, "R11");
      op(1'b0, 0, '0, 1'b1, PROT_ADDR, "R11");
      for (int i = 0; i < NREG; i++) op(1'b0, 0, '0, 1'b1, i, "R11");

      // random mix across all address classes
      for (int n = 0; n < 3000; n++) begin
         int wa, ra, sel;
         bit w, r;
         sel = int'($urandom_range(0, 9));
         wa  = (sel < 6) ? int'($urandom_range(0, NREG-1)) :
               (sel < 8) ? PROT_ADDR : (sel == 8) ? STAT_ADDR : int'($urandom_range(NREG, 55));
         sel = int'($urandom_range(0, 9));
         ra  = (sel < 4) ? int'($urandom_range(0, NREG-1)) :
               (sel < 7) ? STAT_ADDR : (sel < 9) ? PROT_ADDR : int'($urandom_range(58, 63));
         w = ($urandom_range(0, 3) != 0);
         r = ($urandom_range(0, 2) != 0);
         op(w, wa, $urandom(), r, ra, "");
      end

      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule